// File: doc/BRIEF.md
# Priority Interrupt Distributor with Separate Deactivation

This block keeps per-source pending and active state for a set of physical interrupt sources. It presents the most urgent eligible source to a single CPU as an interrupt request together with its ID. Each source has an input line, a trigger style (level or edge), a priority, and a message flag. The message flag marks edge-style requests that have no active state.

The CPU side has three strobes. Acknowledge takes the presented interrupt. End-of-interrupt drops the running priority. Deactivate clears a source's active bit. A control input picks the split mode, in which end-of-interrupt only drops priority and deactivation is a separate step. Without split mode, end-of-interrupt does both. While a source is active it is never forwarded. When it is deactivated, its line is looked at again: a level source comes back only if its line is still high, and an edge source comes back only if an edge arrived while it was active. A software strobe can set a source's active bit directly, with no acknowledge.

Running priority comes from a stack. Acknowledge pushes the priority of the source it takes, and end-of-interrupt pops it. Only sources strictly more urgent than the running priority are forwarded. A lower number means more urgent.

Top module: `irq_distributor`

## Requirements
- R1: A source whose active bit is set is not forwarded, even while it is pending.
- R2: A level source (src_edge_i=0, src_msg_i=0) is pending exactly while its line is high.
- R3: When a level source is deactivated, it is forwarded again only if its line is still high.
- R4: A rising edge on an active edge source (src_edge_i=1) is kept as pending, and the source is forwarded once it is deactivated.
- R5: When an edge source that saw no edge while active is deactivated, no request is raised.
- R6: With split_eoi_i=1, end-of-interrupt drops the running priority but leaves the source active until deactivate, and less urgent sources may be forwarded meanwhile. With split_eoi_i=0, end-of-interrupt also deactivates the source named by eoi_id_i.
- R7: A software strobe sets the active bit of the named source without an acknowledge.
- R8: A message source (src_msg_i=1) never has an active bit. Acknowledge clears its pending state, and deactivate has no effect on it.
- R9: An acknowledge while irq_o is high takes source irq_id_o and sets it active (unless it is a message source). It clears that source's edge-pending bit and pushes its priority as the running priority. Only sources with a priority numerically below the running priority are forwarded.
- R10: End-of-interrupt pops the running-priority stack, restoring the previous value. An empty stack reads 2**PRIO_W (16 by default).
- R11: Among eligible sources of equal priority, the lowest ID wins. With none eligible, irq_o is low and irq_id_o is 1023, and an acknowledge changes nothing.
- R12: After reset no source is pending or active, irq_o is low, irq_id_o is 1023 and the running priority is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_line_i | input | N | Interrupt lines, one per source |
| src_edge_i | input | N | 1 = edge triggered, 0 = level |
| src_msg_i | input | N | 1 = message source, edge style with no active state |
| src_prio_i | input | N*PRIO_W | Priority of source i in bits [i*PRIO_W +: PRIO_W] |
| split_eoi_i | input | 1 | 1 = end-of-interrupt only drops priority |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | 10 | Source ID for end-of-interrupt |
| deact_i | input | 1 | Deactivate strobe |
| deact_id_i | input | 10 | Source ID to deactivate |
| sw_act_set_i | input | 1 | Software set-active strobe |
| sw_act_id_i | input | 10 | Source ID for software set-active |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_id_o | output | 10 | ID of the forwarded source, 1023 when none |
| running_prio_o | output | PRIO_W+1 | Current running priority |

## Verification
The hardest state to reach is an edge source that is both pending and active. Reaching it takes a full acknowledge, a priority drop in split mode and a second edge before the deactivate. The directed sequences build this state step by step and then confirm that the source comes back only after deactivation. A matching run without a second edge confirms that it stays silent. Constrained-random phases, in both end-of-interrupt modes, mix line toggles with every strobe against a bench model. This also covers nested preemption, where a more urgent source is taken while another runs.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ_ID = 10'd1023;

  // idle running priority: one above the least urgent level
  function automatic logic [7:0] idle_level(input int prio_w);
    return 8'(1 << prio_w);
  endfunction

  // strictly more urgent: lower number
  function automatic logic outranks(input logic [7:0] cand, input logic [7:0] run);
    return cand < run;
  endfunction
endpackage

// File: rtl/irqd_src_cell.sv
module irqd_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic is_edge_i,
  input  logic is_msg_i,
  input  logic ack_hit_i,
  input  logic deact_hit_i,
  input  logic sw_set_i,
  output logic pending_o,
  output logic active_o
);
  logic prev_q, edge_pend_q, act_q;
  logic rise;

  assign rise = line_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      edge_pend_q <= 1'b0;
      act_q       <= 1'b0;
    end else begin
      prev_q <= line_i;
      // a new edge wins over an acknowledge in the same cycle
      if (rise)           edge_pend_q <= 1'b1;
      else if (ack_hit_i) edge_pend_q <= 1'b0;
      if (is_msg_i)                    act_q <= 1'b0;
      else if (ack_hit_i || sw_set_i)  act_q <= 1'b1;
      else if (deact_hit_i)            act_q <= 1'b0;
    end
  end

  assign pending_o = (is_edge_i | is_msg_i) ? edge_pend_q : line_i;
  assign active_o  = act_q;
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int N      = 8,
  parameter int PRIO_W = 4
) (
  input  logic [N-1:0]        elig_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                found_o,
  output logic [9:0]          win_id_o,
  output logic [PRIO_W-1:0]   win_prio_o
);
  always_comb begin
    found_o    = 1'b0;
    win_id_o   = irqd_pkg::NO_IRQ_ID;
    win_prio_o = '1;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lowest ID on a tie
      if (elig_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] < win_prio_o)) begin
        found_o    = 1'b1;
        win_id_o   = 10'(i);
        win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqd_prio_stack.sv
module irqd_prio_stack #(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic [PRIO_W:0]   running_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(1 << PRIO_W);

  logic [PRIO_W-1:0] stk_q [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     top_idx, push_idx;

  assign top_idx  = AW'(cnt_q - CW'(1));
  assign push_idx = AW'(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (push_i) begin
      if (cnt_q < CW'(DEPTH)) begin
        stk_q[push_idx] <= push_prio_i;
        cnt_q           <= cnt_q + CW'(1);
      end
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign running_o = (cnt_q == '0) ? IDLE : {1'b0, stk_q[top_idx]};
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int N      = 8,
  parameter int PRIO_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        src_line_i,
  input  logic [N-1:0]        src_edge_i,
  input  logic [N-1:0]        src_msg_i,
  input  logic [N*PRIO_W-1:0] src_prio_i,
  input  logic                split_eoi_i,
  input  logic                ack_i,
  input  logic                eoi_i,
  input  logic [9:0]          eoi_id_i,
  input  logic                deact_i,
  input  logic [9:0]          deact_id_i,
  input  logic                sw_act_set_i,
  input  logic [9:0]          sw_act_id_i,
  output logic                irq_o,
  output logic [9:0]          irq_id_o,
  output logic [PRIO_W:0]     running_prio_o
);
  localparam int DEPTH = 1 << PRIO_W;
  localparam int CW    = $clog2(DEPTH+1);

  // named internal events for the checker
  logic [N-1:0]      pend_vec, act_vec, elig_vec;
  logic [N-1:0]      ack_hit, deact_hit, sw_hit;
  logic              found, take, drop;
  logic [9:0]        win_id;
  logic [PRIO_W-1:0] win_prio;
  logic [CW-1:0]     stack_cnt;

  assign take = ack_i & found;
  assign drop = eoi_i & ~take;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign ack_hit[i]   = take && (win_id == 10'(i));
    assign deact_hit[i] = (deact_i && deact_id_i == 10'(i)) ||
                          (eoi_i && !split_eoi_i && eoi_id_i == 10'(i));
    assign sw_hit[i]    = sw_act_set_i && (sw_act_id_i == 10'(i));
    assign elig_vec[i]  = pend_vec[i] & ~act_vec[i] &
                          irqd_pkg::outranks(8'(src_prio_i[i*PRIO_W +: PRIO_W]),
                                             8'(running_prio_o));

    irqd_src_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (src_line_i[i]),
      .is_edge_i   (src_edge_i[i]),
      .is_msg_i    (src_msg_i[i]),
      .ack_hit_i   (ack_hit[i]),
      .deact_hit_i (deact_hit[i]),
      .sw_set_i    (sw_hit[i]),
      .pending_o   (pend_vec[i]),
      .active_o    (act_vec[i])
    );
  end

  irqd_arbiter #(.N(N), .PRIO_W(PRIO_W)) u_arb (
    .elig_i     (elig_vec),
    .prio_i     (src_prio_i),
    .found_o    (found),
    .win_id_o   (win_id),
    .win_prio_o (win_prio)
  );

  irqd_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (take),
    .push_prio_i (win_prio),
    .pop_i       (drop),
    .running_o   (running_prio_o),
    .cnt_o       (stack_cnt)
  );

  assign irq_o    = found;
  assign irq_id_o = win_id;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int N      = 8,
  parameter int PRIO_W = 4,
  parameter int CW     = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_o,
  input logic [9:0]          irq_id_o,
  input logic [PRIO_W:0]     running_prio_o,
  input logic [N-1:0]        act_vec,
  input logic [N-1:0]        src_msg_i,
  input logic [N*PRIO_W-1:0] src_prio_i,
  input logic                split_eoi_i,
  input logic                ack_i,
  input logic                eoi_i,
  input logic [9:0]          eoi_id_i,
  input logic                deact_i,
  input logic [CW-1:0]       stack_cnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(1 << PRIO_W);

  logic              id_ok, eoi_ok, cur_act, eoi_act;
  logic [IW-1:0]     cur_idx, eoi_idx;
  logic [PRIO_W-1:0] cur_prio;

  assign id_ok    = irq_id_o < 10'(N);
  assign eoi_ok   = eoi_id_i < 10'(N);
  assign cur_idx  = IW'(irq_id_o);
  assign eoi_idx  = IW'(eoi_id_i);
  assign cur_prio = id_ok ? src_prio_i[cur_idx*PRIO_W +: PRIO_W] : '0;
  assign cur_act  = id_ok ? act_vec[cur_idx] : 1'b0;
  assign eoi_act  = eoi_ok ? act_vec[eoi_idx] : 1'b0;

  a_r1_active_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (id_ok && !cur_act));

  a_r9_strictly_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ({1'b0, cur_prio} < running_prio_o));

  a_r9_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> running_prio_o == {1'b0, $past(cur_prio)});

  a_r10_pop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && stack_cnt == CW'(1)) |=> running_prio_o == IDLE);

  a_r11_none_id: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> irq_id_o == 10'd1023);

  a_r8_msg_never_active: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vec & src_msg_i) == '0);

  a_r6_split_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    (split_eoi_i && eoi_i && !deact_i && eoi_act && !src_msg_i[eoi_idx])
      |=> act_vec[$past(eoi_idx)]);
endmodule

bind irq_distributor irqd_checker #(.N(N), .PRIO_W(PRIO_W), .CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_o          (irq_o),
  .irq_id_o       (irq_id_o),
  .running_prio_o (running_prio_o),
  .act_vec        (act_vec),
  .src_msg_i      (src_msg_i),
  .src_prio_i     (src_prio_i),
  .split_eoi_i    (split_eoi_i),
  .ack_i          (ack_i),
  .eoi_i          (eoi_i),
  .eoi_id_i       (eoi_id_i),
  .deact_i        (deact_i),
  .stack_cnt      (stack_cnt)
);

// File: tb/irq_distributor_tb_top.sv
module irq_distributor_tb_top;
  localparam int N = 8;
  localparam int PW = 4;
  localparam int IDLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] line = '0, edg = '0, msg = '0;
  logic [N*PW-1:0] prio = '0;
  logic split = 1'b1, ack = 1'b0, eoi = 1'b0, deact = 1'b0, swset = 1'b0;
  logic [9:0] eoi_id = '0, deact_id = '0, sw_id = '0;
  logic irq_o;
  logic [9:0] irq_id_o;
  logic [PW:0] run_o;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // bench model
  bit m_prev[N], m_pe[N], m_act[N];
  int stk[IDLE], cnt;

  always #5 clk = ~clk;

  irq_distributor #(.N(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_line_i(line), .src_edge_i(edg), .src_msg_i(msg),
    .src_prio_i(prio), .split_eoi_i(split), .ack_i(ack), .eoi_i(eoi), .eoi_id_i(eoi_id),
    .deact_i(deact), .deact_id_i(deact_id), .sw_act_set_i(swset), .sw_act_id_i(sw_id),
    .irq_o(irq_o), .irq_id_o(irq_id_o), .running_prio_o(run_o));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pr(int i);
    return int'(prio[i*PW +: PW]);
  endfunction

  function automatic void expect_now(output bit f, output int id, output int run);
    int best = 99;
    run = (cnt == 0) ? IDLE : stk[cnt-1];
    f = 0; id = 1023;
    for (int i = 0; i < N; i++) begin
      bit p = (edg[i] | msg[i]) ? m_pe[i] : line[i];
      if (p && !m_act[i] && pr(i) < run && pr(i) < best) begin
        best = pr(i); id = i; f = 1;
      end
    end
  endfunction

  function automatic void model_step();
    bit f; int id, run;
    expect_now(f, id, run);
    for (int i = 0; i < N; i++) begin
      bit rise = line[i] && !m_prev[i];
      bit ah = ack && f && id == i;
      bit dh = (deact && deact_id == 10'(i)) || (eoi && !split && eoi_id == 10'(i));
      bit sh = swset && sw_id == 10'(i);
      if (rise) m_pe[i] = 1; else if (ah) m_pe[i] = 0;
      if (msg[i]) m_act[i] = 0;
      else if (ah || sh) m_act[i] = 1;
      else if (dh) m_act[i] = 0;
      m_prev[i] = line[i];
    end
    if (ack && f) begin stk[cnt] = pr(id); cnt++; end
    else if (eoi && cnt > 0) cnt--;
  endfunction

  task automatic cyc();
    bit f; int id, run;
    #1;
    expect_now(f, id, run);
    chk("R9 irq", int'(irq_o), int'(f));
    chk("R11 id", int'(irq_id_o), id);
    chk("R10 running", int'(run_o), run);
    @(posedge clk);
    model_step();
    @(negedge clk);
    ack = 0; eoi = 0; deact = 0; swset = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; line = '0; ack = 0; eoi = 0; deact = 0; swset = 0;
    for (int i = 0; i < N; i++) begin m_prev[i] = 0; m_pe[i] = 0; m_act[i] = 0; end
    cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulse(int i);
    line[i] = 1; cyc(); line[i] = 0;
  endtask
  task automatic do_ack();         ack = 1; cyc(); endtask
  task automatic do_eoi(int i);    eoi = 1; eoi_id = 10'(i); cyc(); endtask
  task automatic do_deact(int i);  deact = 1; deact_id = 10'(i); cyc(); endtask

  task automatic dir_config(bit s);
    split = s; edg = 8'b1111_0010; msg = 8'b0000_0100;
    for (int i = 0; i < N; i++) prio[i*PW +: PW] = 4'd7;
    prio[0*PW +: PW] = 4'd5; prio[1*PW +: PW] = 4'd3;
    prio[2*PW +: PW] = 4'd2; prio[3*PW +: PW] = 4'd3;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    dir_config(1);
    @(negedge clk);
    do_reset();
    #1;
    chk("R12 irq", int'(irq_o), 0); chk("R12 id", int'(irq_id_o), 1023);
    chk("R12 running", int'(run_o), IDLE);
    do_ack(); #1;
    chk("R11 empty ack keeps running", int'(run_o), IDLE);
    chk("R11 empty id", int'(irq_id_o), 1023);
    line[0] = 1; #1;
    chk("R2 level forwarded", int'(irq_id_o), 0);
    cyc();
    swset = 1; sw_id = 10'd0; cyc(); #1;
    chk("R7 R1 sw active blocks", int'(irq_o), 0);
    do_deact(0); #1;
    chk("R3 line high refires", int'(irq_id_o), 0);
    do_ack(); #1;
    chk("R9 running pushed", int'(run_o), 5);
    chk("R1 acked level blocked", int'(irq_o), 0);
    line[0] = 0; do_eoi(0); #1;
    chk("R10 drop to idle", int'(run_o), IDLE);
    line[0] = 1; #1;
    chk("R6 split keeps active", int'(irq_o), 0);
    line[0] = 0; do_deact(0); #1;
    chk("R3 line low no refire", int'(irq_o), 0);
    pulse(1); #1;
    chk("R4 edge forwarded", int'(irq_id_o), 1);
    do_ack(); do_eoi(1);
    pulse(1); #1;
    chk("R4 edge held while active", int'(irq_o), 0);
    do_deact(1); #1;
    chk("R4 refire after deactivate", int'(irq_id_o), 1);
    do_ack(); do_eoi(1); do_deact(1); #1;
    chk("R5 no edge no refire", int'(irq_o), 0);
    pulse(2); #1;
    chk("R8 msg forwarded", int'(irq_id_o), 2);
    do_ack(); #1;
    chk("R8 msg pushes running", int'(run_o), 2);
    chk("R8 msg pending cleared", int'(irq_o), 0);
    do_eoi(2); pulse(2); #1;
    chk("R8 msg no active state", int'(irq_id_o), 2);
    do_deact(2); #1;
    chk("R8 deactivate no effect", int'(irq_id_o), 2);
    do_ack(); do_eoi(2);
    line[3] = 1; pulse(1); #1;
    chk("R11 tie lowest id", int'(irq_id_o), 1);
    do_ack(); #1;
    chk("R9 equal prio not forwarded", int'(irq_o), 0);
    do_eoi(1); #1;
    chk("R6 lower prio taken while active", int'(irq_id_o), 3);

    dir_config(0);
    do_reset();
    line[0] = 1; cyc(); do_ack();
    pulse(1); #1;
    chk("R9 preempt more urgent", int'(irq_id_o), 1);
    do_ack(); do_eoi(1); #1;
    chk("R10 restores previous", int'(run_o), 5);
    do_eoi(0); #1;
    chk("R6 eoi deactivates non-split", int'(irq_id_o), 0);
    chk("R10 stack empty", int'(run_o), IDLE);

    for (int ph = 0; ph < 4; ph++) begin
      split = ph[0];
      for (int i = 0; i < N; i++) prio[i*PW +: PW] = 4'($urandom_range(0, 15));
      edg = 8'($urandom); msg = 8'($urandom) & 8'($urandom);
      do_reset();
      for (int c = 0; c < 2500; c++) begin
        for (int i = 0; i < N; i++) if ($urandom_range(0, 7) == 0) line[i] = ~line[i];
        ack   = ($urandom_range(0, 4) == 0);
        eoi   = ($urandom_range(0, 6) == 0);  eoi_id   = 10'($urandom_range(0, N));
        deact = ($urandom_range(0, 9) == 0);  deact_id = 10'($urandom_range(0, N));
        swset = ($urandom_range(0, 19) == 0); sw_id    = 10'($urandom_range(0, N-1));
        cyc();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule